// File: doc/BRIEF.md
# Uncached Access Combining Buffer

This block sits between a processor core and the memory bus and gathers uncached loads and stores into a small FIFO. Each FIFO entry covers one whole cache line. An incoming request either folds into the youngest entry, when that entry has the same type and the same line, or it opens a new entry at the tail. The oldest entry goes downstream as a single line-wide transaction with a per-byte mask and a count of the requests folded into it. One transaction is outstanding at a time. The head entry leaves the FIFO only when the bus signals completion.

Several controls limit folding. A combine-enable input turns it on or off. A merge limit caps the number of requests per entry. A fence pulse seals the youngest entry. An entry that is in flight is busy and cannot take more requests. A flush level sets how many occupied entries force the head out. Conditional stores have a separate one-entry slot. They never fold into anything, and while one is pending the FIFO drains ahead of it.

The issue controller is a three-state machine. In IDLE nothing is offered. In OFFER a line is presented with `bus_valid` high. In AWAIT the controller waits for `bus_done`. The transitions are:
- IDLE to OFFER, taking the FIFO head, when the issue trigger holds.
- IDLE to OFFER, taking the conditional slot, when that slot is full and the FIFO is empty.
- OFFER to AWAIT on `bus_ready`.
- AWAIT to IDLE on `bus_done`, which also retires the source entry.

Top module: `ucb_buf`

## Requirements
- R1: After reset the FIFO and the conditional slot are empty, `bus_valid` is 0 and `req_ready` is 1.
- R2: With combining enabled, a queue request folds into the youngest entry when that entry has the same type (`req_write`) and the same line address (`req_addr` above the line offset). The fold merges the byte masks and raises `bus_count` by one. For writes, a later write to a byte replaces that byte's earlier data.
- R3: `req_size` encodes 0=1, 1=2, 2=4, 3=8 and 4=16 bytes. The access covers that many bytes, starting at the line offset rounded down to a multiple of the size. `bus_bmask` bit j stands for byte j of the line, and `bus_wdata[8j+7:8j]` is that byte's data.
- R4: A queue request whose type or line differs from the youngest entry opens a new entry.
- R5: A `req_fence` pulse seals the youngest entry, so no later request folds into it. While any sealed entry is present, the FIFO is drained regardless of the flush level.
- R6: A head entry in flight never accepts a fold, and the offered line stays stable until `bus_ready`.
- R7: With `cfg_combine_en` at 0, every queue request opens its own entry.
- R8: An entry that already holds `cfg_merge_limit` requests refuses further folds.
- R9: The head is issued once occupancy reaches `cfg_flush_level` or the FIFO is full. Below the level, with no seal and no pending conditional store, nothing is issued.
- R10: When the FIFO is full and the request cannot fold, `req_ready` is 0 and the request is not taken. A request that can fold is still taken.
- R11: A request with `req_cond` at 1 is a conditional store. It goes into the one-entry slot, never folds, and is issued with `bus_cond` at 1 and `bus_count` at 1, after the FIFO has drained. While the slot is full, further conditional stores see `req_ready` at 0.
- R12: After `bus_ready` is accepted, `bus_valid` stays low until `bus_done` retires the entry. Only one transaction is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_combine_en | input | 1 | Enable folding of requests |
| cfg_merge_limit | input | CNT_W | Maximum requests per entry |
| cfg_flush_level | input | OCC_W | Occupancy that forces issue of the head |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_cond | input | 1 | Conditional store (goes to the separate slot) |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Size code, 0..4 for 1..16 bytes |
| req_wdata | input | LINE_BYTES*8 | Store data, placed in its line byte lanes |
| req_fence | input | 1 | Seal the youngest entry |
| bus_valid | output | 1 | Line transaction offered |
| bus_ready | input | 1 | Bus accepts the offer |
| bus_write | output | 1 | Offered line is a store |
| bus_cond | output | 1 | Offered line is a conditional store |
| bus_addr | output | ADDR_W | Line-aligned address |
| bus_bmask | output | LINE_BYTES | Bytes touched in the line |
| bus_wdata | output | LINE_BYTES*8 | Merged store data |
| bus_count | output | CNT_W | Number of requests folded into the line |
| bus_done | input | 1 | Completion of the outstanding transaction |

## Verification
Two situations are the hardest to set up from the ports.

The first is the busy-head refusal. A fold is refused only when the youngest entry is also the head and is already on the bus. To create this, the bench sets the flush level to 1 and holds `bus_ready` low, so the first line stays offered. It waits until `bus_valid` is seen, then sends a same-line store and expects that store to come out as a second, separate transaction.

The second is the full-FIFO case, where one request must stall and another must still be taken. The bench fills the FIFO with alternating types. It then sends a request that matches the youngest entry and expects it to be taken, followed by a new-line request that must see `req_ready` low.

// File: rtl/ucb_pkg.sv
package ucb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_AWAIT = 2'd2
    } ucb_state_e;

    localparam int SIZE_CODE_W = 3;

endpackage

// File: rtl/ucb_lane_dec.sv
module ucb_lane_dec #(
    parameter int LINE_BYTES = 16,
    localparam int OFS_W = $clog2(LINE_BYTES)
) (
    input  logic [OFS_W-1:0]            ofs,
    input  logic [ucb_pkg::SIZE_CODE_W-1:0] size,
    output logic [LINE_BYTES-1:0]       mask
);
    int nbytes;
    int base;

    always_comb begin
        if (int'(size) >= OFS_W) begin
            nbytes = LINE_BYTES;
        end else begin
            nbytes = 1 << int'(size);
        end
        base = (int'(ofs) / nbytes) * nbytes;
        for (int j = 0; j < LINE_BYTES; j++) begin
            mask[j] = (j >= base) && (j < base + nbytes);
        end
    end
endmodule

// File: rtl/ucb_issue_fsm.sv
module ucb_issue_fsm
    import ucb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic q_go,
    input  logic c_go,
    input  logic bus_ready,
    input  logic bus_done,
    output logic bus_valid,
    output logic src_cond,
    output logic idle,
    output logic pop_q,
    output logic pop_c
);
    ucb_state_e state_q, state_d;
    logic       src_q, src_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            ST_IDLE: begin
                if (q_go) begin
                    state_d = ST_OFFER;
                    src_d   = 1'b0;
                end else if (c_go) begin
                    state_d = ST_OFFER;
                    src_d   = 1'b1;
                end
            end
            ST_OFFER: begin
                if (bus_ready) state_d = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (bus_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_valid = 1'b0;
        idle      = 1'b0;
        pop_q     = 1'b0;
        pop_c     = 1'b0;
        src_cond  = src_q;
        unique case (state_q)
            ST_IDLE:  idle      = 1'b1;
            ST_OFFER: bus_valid = 1'b1;
            ST_AWAIT: begin
                pop_q = bus_done && !src_q;
                pop_c = bus_done &&  src_q;
            end
            default: idle = 1'b1;
        endcase
    end
endmodule

// File: rtl/ucb_buf.sv
module ucb_buf #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int DEPTH      = 4,
    parameter int MAX_MERGE  = 8,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int TAG_W     = ADDR_W - OFS_W,
    localparam int PTR_W     = $clog2(DEPTH),
    localparam int OCC_W     = $clog2(DEPTH + 1),
    localparam int CNT_W     = $clog2(MAX_MERGE + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_combine_en,
    input  logic [CNT_W-1:0]      cfg_merge_limit,
    input  logic [OCC_W-1:0]      cfg_flush_level,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic                  req_cond,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [2:0]            req_size,
    input  logic [LINE_BITS-1:0]  req_wdata,
    input  logic                  req_fence,
    output logic                  bus_valid,
    input  logic                  bus_ready,
    output logic                  bus_write,
    output logic                  bus_cond,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [LINE_BYTES-1:0] bus_bmask,
    output logic [LINE_BITS-1:0]  bus_wdata,
    output logic [CNT_W-1:0]      bus_count,
    input  logic                  bus_done
);
    // entry storage
    logic [TAG_W-1:0]      e_tag   [DEPTH];
    logic                  e_write [DEPTH];
    logic                  e_fence [DEPTH];
    logic [CNT_W-1:0]      e_cnt   [DEPTH];
    logic [LINE_BYTES-1:0] e_mask  [DEPTH];
    logic [LINE_BITS-1:0]  e_data  [DEPTH];

    logic [PTR_W-1:0] head_q, tail_q, yng;
    logic [OCC_W-1:0] occ_q;

    // conditional slot
    logic                  cv_q;
    logic [TAG_W-1:0]      c_tag;
    logic [LINE_BYTES-1:0] c_mask;
    logic [LINE_BITS-1:0]  c_data;

    logic [LINE_BYTES-1:0] lane_mask;
    logic [TAG_W-1:0]      req_tag;
    logic fsm_idle, src_cond, pop_q, pop_c, head_busy;
    logic can_merge, q_req, c_req, do_merge, do_alloc, do_cstore;
    logic full, any_fence, q_go, c_go;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
    endfunction

    ucb_lane_dec #(.LINE_BYTES(LINE_BYTES)) u_lane (
        .ofs  (req_addr[OFS_W-1:0]),
        .size (req_size),
        .mask (lane_mask)
    );

    ucb_issue_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_go      (q_go),
        .c_go      (c_go),
        .bus_ready (bus_ready),
        .bus_done  (bus_done),
        .bus_valid (bus_valid),
        .src_cond  (src_cond),
        .idle      (fsm_idle),
        .pop_q     (pop_q),
        .pop_c     (pop_c)
    );

    assign req_tag   = req_addr[ADDR_W-1:OFS_W];
    assign yng       = ptr_dec(tail_q);
    assign full      = (occ_q == OCC_W'(DEPTH));
    assign head_busy = !fsm_idle && !src_cond;

    always_comb begin
        can_merge = cfg_combine_en && (occ_q != '0)
                 && !e_fence[yng]
                 && !((yng == head_q) && head_busy)
                 && (e_write[yng] == req_write)
                 && (e_tag[yng] == req_tag)
                 && (e_cnt[yng] < cfg_merge_limit);
    end

    assign q_req     = req_valid && !req_cond;
    assign c_req     = req_valid &&  req_cond;
    assign do_merge  = q_req && can_merge;
    assign do_alloc  = q_req && !can_merge && !full;
    assign do_cstore = c_req && !cv_q;
    assign req_ready = req_cond ? !cv_q : (can_merge || !full);

    // a seal on any live entry forces the FIFO to drain
    always_comb begin
        any_fence = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (((i - int'(head_q) + DEPTH) % DEPTH) < int'(occ_q) && e_fence[i])
                any_fence = 1'b1;
        end
    end

    assign q_go = (occ_q != '0)
               && ((occ_q >= cfg_flush_level) || full || any_fence || cv_q);
    assign c_go = cv_q && (occ_q == '0);

    // control state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
            cv_q   <= 1'b0;
        end else begin
            if (do_alloc) tail_q <= ptr_inc(tail_q);
            if (pop_q)    head_q <= ptr_inc(head_q);
            occ_q <= occ_q + OCC_W'(do_alloc) - OCC_W'(pop_q);
            if (do_cstore)  cv_q <= 1'b1;
            else if (pop_c) cv_q <= 1'b0;
        end
    end

    // entry payload
    always_ff @(posedge clk) begin
        if (do_alloc) begin
            e_tag[tail_q]   <= req_tag;
            e_write[tail_q] <= req_write;
            e_fence[tail_q] <= 1'b0;
            e_cnt[tail_q]   <= CNT_W'(1);
            e_mask[tail_q]  <= lane_mask;
            for (int b = 0; b < LINE_BYTES; b++)
                e_data[tail_q][8*b +: 8] <= lane_mask[b] ? req_wdata[8*b +: 8] : 8'h00;
        end
        if (do_merge) begin
            e_cnt[yng]  <= e_cnt[yng] + 1'b1;
            e_mask[yng] <= e_mask[yng] | lane_mask;
            for (int b = 0; b < LINE_BYTES; b++)
                if (lane_mask[b]) e_data[yng][8*b +: 8] <= req_wdata[8*b +: 8];
        end
        if (req_fence && (do_alloc || occ_q != '0)) begin
            e_fence[do_alloc ? tail_q : yng] <= 1'b1;
        end
        if (do_cstore) begin
            c_tag  <= req_tag;
            c_mask <= lane_mask;
            for (int b = 0; b < LINE_BYTES; b++)
                c_data[8*b +: 8] <= lane_mask[b] ? req_wdata[8*b +: 8] : 8'h00;
        end
    end

    // downstream view
    always_comb begin
        if (src_cond) begin
            bus_write = 1'b1;
            bus_cond  = 1'b1;
            bus_addr  = {c_tag, {OFS_W{1'b0}}};
            bus_bmask = c_mask;
            bus_wdata = c_data;
            bus_count = CNT_W'(1);
        end else begin
            bus_write = e_write[head_q];
            bus_cond  = 1'b0;
            bus_addr  = {e_tag[head_q], {OFS_W{1'b0}}};
            bus_bmask = e_mask[head_q];
            bus_wdata = e_data[head_q];
            bus_count = e_cnt[head_q];
        end
    end
endmodule

// File: rtl/ucb_buf_chk.sv
module ucb_buf_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int DEPTH      = 4,
    parameter int MAX_MERGE  = 8,
    localparam int OCC_W     = $clog2(DEPTH + 1),
    localparam int CNT_W     = $clog2(MAX_MERGE + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [OCC_W-1:0]      occ_q,
    input logic                  fsm_idle,
    input logic [OCC_W-1:0]      cfg_flush_level,
    input logic                  req_valid,
    input logic                  req_cond,
    input logic                  req_ready,
    input logic                  bus_valid,
    input logic                  bus_ready,
    input logic                  bus_cond,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [LINE_BYTES-1:0] bus_bmask,
    input logic [CNT_W-1:0]      bus_count
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(DEPTH)); // R10

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                   && $stable(bus_bmask) && $stable(bus_count)); // R6

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_ready |=> !bus_valid); // R12

    AST_FLUSH_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle && occ_q != '0 && occ_q >= cfg_flush_level |=> bus_valid); // R9

    AST_COND_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_cond && req_valid && req_cond |-> !req_ready); // R11
endmodule

bind ucb_buf ucb_buf_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DEPTH(DEPTH), .MAX_MERGE(MAX_MERGE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .occ_q(occ_q), .fsm_idle(fsm_idle),
    .cfg_flush_level(cfg_flush_level), .req_valid(req_valid), .req_cond(req_cond),
    .req_ready(req_ready), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_cond(bus_cond), .bus_addr(bus_addr), .bus_bmask(bus_bmask),
    .bus_count(bus_count)
);

// File: tb/ucb_buf_test.sv
`timescale 1ns/1ps
module ucb_buf_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_combine_en = 1'b1;
    logic [3:0]   cfg_merge_limit = 4'd4;
    logic [2:0]   cfg_flush_level = 3'd4;
    logic         req_valid = 1'b0, req_write = 1'b0, req_cond = 1'b0, req_fence = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [2:0]   req_size = '0;
    logic [127:0] req_wdata = '0;
    logic         bus_valid, bus_write, bus_cond;
    logic         bus_ready = 1'b0, bus_done = 1'b0;
    logic [31:0]  bus_addr;
    logic [15:0]  bus_bmask;
    logic [127:0] bus_wdata;
    logic [3:0]   bus_count;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ucb_buf uut (
        .clk(clk), .rst_n(rst_n), .cfg_combine_en(cfg_combine_en),
        .cfg_merge_limit(cfg_merge_limit), .cfg_flush_level(cfg_flush_level),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_cond(req_cond), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .req_fence(req_fence), .bus_valid(bus_valid),
        .bus_ready(bus_ready), .bus_write(bus_write), .bus_cond(bus_cond),
        .bus_addr(bus_addr), .bus_bmask(bus_bmask), .bus_wdata(bus_wdata),
        .bus_count(bus_count), .bus_done(bus_done)
    );

    task automatic check(input string rq, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [127:0] expand(input logic [15:0] m);
        logic [127:0] r;
        for (int b = 0; b < 16; b++) r[8*b +: 8] = {8{m[b]}};
        return r;
    endfunction

    task automatic send(input bit wr, input bit cnd, input logic [31:0] a,
                        input logic [2:0] sz, input logic [127:0] d, output bit acc);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_cond = cnd;
        req_addr = a; req_size = sz; req_wdata = d;
        #0.5 acc = req_ready;
        @(posedge clk);
        #0.5 req_valid = 1'b0; req_cond = 1'b0;
    endtask

    task automatic fence();
        @(negedge clk);
        req_fence = 1'b1;
        @(posedge clk);
        #0.5 req_fence = 1'b0;
    endtask

    task automatic quiet(input string rq, input int n);
        repeat (n) @(negedge clk);
        check(rq, "no issue expected", 128'(bus_valid), 128'(0));
    endtask

    task automatic expect_issue(input string rq, input logic [31:0] ea, input bit ew,
                                input bit ec, input logic [15:0] em, input logic [3:0] en,
                                input logic [127:0] ed);
        int w = 0;
        @(negedge clk);
        while (!bus_valid && w < 40) begin
            @(negedge clk);
            w++;
        end
        check(rq, "bus_valid", 128'(bus_valid), 128'(1));
        check(rq, "bus_addr", 128'(bus_addr), 128'(ea));
        check(rq, "bus_write", 128'(bus_write), 128'(ew));
        check(rq, "bus_cond", 128'(bus_cond), 128'(ec));
        check(rq, "bus_bmask", 128'(bus_bmask), 128'(em));
        check(rq, "bus_count", 128'(bus_count), 128'(en));
        check(rq, "bus_wdata", bus_wdata & expand(em), ed);
        bus_ready = 1'b1;
        @(posedge clk);
        #0.5 bus_ready = 1'b0;
        @(negedge clk);
        check("R12", "valid low while awaiting done", 128'(bus_valid), 128'(0));
        bus_done = 1'b1;
        @(posedge clk);
        #0.5 bus_done = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "req_ready after reset", 128'(req_ready), 128'(1));
        check("R1", "bus_valid after reset", 128'(bus_valid), 128'(0));
    endtask

    task automatic t_merge();
        bit a;
        cfg_flush_level = 3'd4; cfg_combine_en = 1'b1; cfg_merge_limit = 4'd4;
        send(1, 0, 32'h100, 3'd2, 128'h11223344, a);
        check("R2", "first store taken", 128'(a), 128'(1));
        send(1, 0, 32'h104, 3'd2, 128'h55667788 << 32, a);
        send(1, 0, 32'h100, 3'd0, 128'hEE, a);
        quiet("R9", 4);
        fence();
        expect_issue("R2", 32'h100, 1, 0, 16'h00FF, 4'd3, 128'h55667788_112233EE);
    endtask

    task automatic t_align();
        bit a;
        send(1, 0, 32'h10B, 3'd1, 128'hBEEF << 80, a);
        send(1, 0, 32'h10F, 3'd3, 128'h01020304_05060708 << 64, a);
        fence();
        expect_issue("R3", 32'h100, 1, 0, 16'hFF00, 4'd2, 128'h01020304_05060708 << 64);
    endtask

    task automatic t_types_full();
        bit a;
        send(1, 0, 32'h200, 3'd2, 128'h0, a);
        send(0, 0, 32'h200, 3'd2, 128'h0, a);
        send(1, 0, 32'h300, 3'd2, 128'h0, a);
        send(0, 0, 32'h300, 3'd2, 128'h0, a);
        send(0, 0, 32'h308, 3'd2, 128'h0, a);
        check("R10", "fold taken while full", 128'(a), 128'(1));
        send(1, 0, 32'h400, 3'd2, 128'h0, a);
        check("R10", "new line stalls while full", 128'(a), 128'(0));
        fence();
        expect_issue("R4", 32'h200, 1, 0, 16'h000F, 4'd1, 128'h0);
        expect_issue("R4", 32'h200, 0, 0, 16'h000F, 4'd1, 128'h0);
        expect_issue("R4", 32'h300, 1, 0, 16'h000F, 4'd1, 128'h0);
        expect_issue("R10", 32'h300, 0, 0, 16'h0F0F, 4'd2, 128'h0);
    endtask

    task automatic t_busy();
        bit a;
        cfg_flush_level = 3'd1;
        send(1, 0, 32'h500, 3'd2, 128'hAAAAAAAA, a);
        repeat (2) @(negedge clk);
        check("R6", "head offered", 128'(bus_valid), 128'(1));
        send(1, 0, 32'h504, 3'd2, 128'hBBBBBBBB << 32, a);
        expect_issue("R6", 32'h500, 1, 0, 16'h000F, 4'd1, 128'hAAAAAAAA);
        expect_issue("R6", 32'h500, 1, 0, 16'h00F0, 4'd1, 128'hBBBBBBBB << 32);
        cfg_flush_level = 3'd4;
    endtask

    task automatic t_nocomb();
        bit a;
        cfg_combine_en = 1'b0;
        send(0, 0, 32'h600, 3'd0, 128'h0, a);
        send(0, 0, 32'h601, 3'd0, 128'h0, a);
        send(0, 0, 32'h602, 3'd0, 128'h0, a);
        quiet("R7", 3);
        fence();
        expect_issue("R7", 32'h600, 0, 0, 16'h0001, 4'd1, 128'h0);
        expect_issue("R7", 32'h600, 0, 0, 16'h0002, 4'd1, 128'h0);
        expect_issue("R5", 32'h600, 0, 0, 16'h0004, 4'd1, 128'h0);
        cfg_combine_en = 1'b1;
    endtask

    task automatic t_limit();
        bit a;
        cfg_merge_limit = 4'd2;
        for (int k = 0; k < 4; k++)
            send(1, 0, 32'h700 + k, 3'd0, 128'(8'h10 + k) << (8 * k), a);
        fence();
        expect_issue("R8", 32'h700, 1, 0, 16'h0003, 4'd2, 128'h1110);
        expect_issue("R8", 32'h700, 1, 0, 16'h000C, 4'd2, 128'h13120000);
        cfg_merge_limit = 4'd4;
    endtask

    task automatic t_flush();
        bit a;
        cfg_flush_level = 3'd2;
        send(1, 0, 32'h800, 3'd2, 128'h12345678, a);
        quiet("R9", 4);
        send(0, 0, 32'h900, 3'd2, 128'h0, a);
        expect_issue("R9", 32'h800, 1, 0, 16'h000F, 4'd1, 128'h12345678);
        fence();
        expect_issue("R5", 32'h900, 0, 0, 16'h000F, 4'd1, 128'h0);
        cfg_flush_level = 3'd4;
    endtask

    task automatic t_cond();
        bit a;
        send(1, 0, 32'hA00, 3'd2, 128'h01020304, a);
        send(1, 1, 32'hA04, 3'd2, 128'hCAFEBABE << 32, a);
        check("R11", "cond store taken", 128'(a), 128'(1));
        send(1, 1, 32'hB00, 3'd2, 128'h0, a);
        check("R11", "second cond store stalls", 128'(a), 128'(0));
        expect_issue("R11", 32'hA00, 1, 0, 16'h000F, 4'd1, 128'h01020304);
        expect_issue("R11", 32'hA00, 1, 1, 16'h00F0, 4'd1, 128'hCAFEBABE << 32);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        t_reset();
        t_merge();
        t_align();
        t_types_full();
        t_busy();
        t_nocomb();
        t_limit();
        t_flush();
        t_cond();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule